// File: doc/BRIEF.md
# Iterating Priority Match Resolver

This block keeps the per-entry match flags produced by the latest comparison and reports which matching entry has the highest priority. The lowest index has the highest priority. A load strobe captures a new match vector and a page number. Each advance strobe then drops the current winner, so the block steps through every match in priority order, one per command. After each step the reported page and entry address change to the new winner.

The reported address is 16 bits wide. The upper four bits hold the page and the lower twelve bits hold the entry index. A match-valid output goes low once no flag remains. A downstream read path can use that output to leave its data bus undriven. The comparison logic and the storage array sit outside this block.

Top module: `prio_match_walker`

## Requirements
- R1: After reset, hit_o is 0 and addr_o is 16'h0000.
- R2: One cycle after a load strobe, hit_o is 1 exactly when the loaded match vector has any bit set. addr_o[11:0] is then the index of the lowest set bit, zero-extended.
- R3: addr_o[15:12] shows the page value captured with the most recent load. It stays unchanged until the next load and reads 0 after reset.
- R4: An advance strobe without a load, while a match is present, clears the current winner's flag. On the next cycle addr_o[11:0] reports the next-lowest set index, or hit_o is 0 if no flag remains.
- R5: When load and advance are asserted in the same cycle, the load is applied and the advance has no effect. The full new vector becomes visible on the next cycle.
- R6: An advance strobe when no match remains leaves hit_o at 0 and addr_o unchanged.
- R7: Whenever hit_o is 0, addr_o[11:0] is 0.
- R8: With neither strobe asserted, hit_o and addr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture a new match vector and page |
| match_vec_i | input | 16 | Match flags from the comparison, bit i set when entry i matched |
| adv_i | input | 1 | Drop the current winner and move to the next match |
| page_i | input | 4 | Page number captured at load |
| hit_o | output | 1 | At least one match remains |
| addr_o | output | 16 | Page in bits 15:12, winner index in bits 11:0 |

## Verification
Directed vectors cover the main cases:
- An empty vector, which tells the no-match output apart from a match at entry 0.
- A vector with only its two end bits set, which shows that the lowest index wins and that one advance reaches the far end.
- The all-ones vector, which walks every entry in turn.

Further cases check that an advance on an empty state is ignored and that a load beats a simultaneous advance. Random loads, advances and idle cycles, with random vectors and pages, are compared against a bench model of the flags. This exposes errors in the clearing order, in page capture and in hold behaviour.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int PAGE_W  = 4;
  localparam int ENTRY_W = 12;
  localparam int ADDR_W  = PAGE_W + ENTRY_W;

  typedef logic [ADDR_W-1:0]  pmw_addr_t;
  typedef logic [PAGE_W-1:0]  pmw_page_t;
  typedef logic [ENTRY_W-1:0] pmw_entry_t;

  // Join page and entry index into the externally visible address.
  function automatic pmw_addr_t pack_addr(input pmw_page_t page, input pmw_entry_t entry);
    return {page, entry};
  endfunction
endpackage

// File: rtl/pmw_prio_enc.sv
module pmw_prio_enc #(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] flags_i,
  output logic [N_ENTRIES-1:0] grant_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic                 any_o
);
  // seen[i] is set when some entry below i is flagged
  logic [N_ENTRIES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_chain
    assign grant_o[i]  = flags_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | flags_i[i];
  end

  assign any_o = seen[N_ENTRIES];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (grant_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o) && (any_o == (grant_o != '0))); // R2
endmodule

// File: rtl/pmw_flag_reg.sv
module pmw_flag_reg #(
  parameter int N_ENTRIES = 16,
  parameter int PAGE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [N_ENTRIES-1:0] vec_i,
  input  logic                 adv_i,
  input  logic [PAGE_W-1:0]    page_i,
  input  logic [N_ENTRIES-1:0] grant_i,
  output logic [N_ENTRIES-1:0] flags_o,
  output logic [PAGE_W-1:0]    page_o
);
  // Named events for checking
  logic load_evt;
  logic adv_evt;
  logic adv_empty_evt;

  assign load_evt      = load_i;
  assign adv_evt       = adv_i & ~load_i & (|flags_o);
  assign adv_empty_evt = adv_i & ~load_i & ~(|flags_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_o <= '0;
      page_o  <= '0;
    end else if (load_evt) begin
      flags_o <= vec_i;
      page_o  <= page_i;
    end else if (adv_evt) begin
      flags_o <= flags_o & ~grant_i;
    end
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (flags_o == $past(vec_i)) && (page_o == $past(page_i))); // R5
  AST_ADV_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> $countones(flags_o) + 1 == $countones($past(flags_o))); // R4
  AST_EMPTY_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    adv_empty_evt |=> (flags_o == '0) && $stable(page_o)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(flags_o) && $stable(page_o)); // R8
endmodule

// File: rtl/pmw_addr_fmt.sv
module pmw_addr_fmt
  import pmw_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  pmw_page_t        page_i,
  output logic             hit_o,
  output pmw_addr_t        addr_o
);
  pmw_entry_t entry;

  assign entry  = any_i ? ENTRY_W'(idx_i) : '0;
  assign hit_o  = any_i;
  assign addr_o = pack_addr(page_i, entry);
endmodule

// File: rtl/prio_match_walker.sv
module prio_match_walker
  import pmw_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [N_ENTRIES-1:0] match_vec_i,
  input  logic                 adv_i,
  input  logic [PAGE_W-1:0]    page_i,
  output logic                 hit_o,
  output logic [ADDR_W-1:0]    addr_o
);
  logic [N_ENTRIES-1:0] flags;
  logic [N_ENTRIES-1:0] grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 win_any;
  pmw_page_t            page_q;

  pmw_flag_reg #(.N_ENTRIES(N_ENTRIES), .PAGE_W(PAGE_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .vec_i   (match_vec_i),
    .adv_i   (adv_i),
    .page_i  (page_i),
    .grant_i (grant),
    .flags_o (flags),
    .page_o  (page_q)
  );

  pmw_prio_enc #(.N_ENTRIES(N_ENTRIES)) u_enc (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags),
    .grant_o (grant),
    .idx_o   (win_idx),
    .any_o   (win_any)
  );

  pmw_addr_fmt #(.IDX_W(IDX_W)) u_fmt (
    .any_i  (win_any),
    .idx_i  (win_idx),
    .page_i (page_q),
    .hit_o  (hit_o),
    .addr_o (addr_o)
  );

  AST_NO_HIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> addr_o[ENTRY_W-1:0] == '0); // R7
  AST_ADV_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && hit_o) |=>
      (!hit_o || addr_o[ENTRY_W-1:0] > $past(addr_o[ENTRY_W-1:0]))); // R4
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(addr_o[ADDR_W-1:ENTRY_W])); // R3
endmodule

// File: tb/prio_match_walker_tb.sv
module prio_match_walker_tb;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [N-1:0]  match_vec_i = '0;
  logic          adv_i = 1'b0;
  logic [3:0]    page_i = '0;
  logic          hit_o;
  logic [15:0]   addr_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [N-1:0] m_flags = '0;
  logic [3:0]   m_page = '0;

  always #10 clk = ~clk;

  prio_match_walker #(.N_ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .match_vec_i(match_vec_i),
    .adv_i(adv_i), .page_i(page_i), .hit_o(hit_o), .addr_o(addr_o)
  );

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic [16:0] expect_out(input logic [N-1:0] v, input logic [3:0] pg);
    int w;
    w = lowest(v);
    if (w < 0) return {1'b0, pg, 12'h000};
    return {1'b1, pg, 12'(w)};
  endfunction

  task automatic check(input string tag);
    logic [16:0] exp;
    exp = expect_out(m_flags, m_page);
    n_chk++;
    if ({hit_o, addr_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: hit/addr = %b/%h, expected %b/%h", tag, hit_o, addr_o, exp[16], exp[15:0]);
    end
  endtask

  // One cycle: drive at negedge, update model at posedge, check mid-high.
  task automatic cyc(input logic ld, input logic [N-1:0] v, input logic ad,
                     input logic [3:0] pg, input string tag);
    @(negedge clk);
    load_i = ld; match_vec_i = v; adv_i = ad; page_i = pg;
    @(posedge clk);
    if (ld) begin
      m_flags = v; m_page = pg;
    end else if (ad && m_flags != '0) begin
      m_flags[lowest(m_flags)] = 1'b0;
    end
    #5;
    check(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed_0017;
    void'($urandom(seed));
    #35;
    check("R1");
    rst_n = 1'b1;
    cyc(0, '0, 0, 4'h0, "R1");
    cyc(1, 16'h0000, 0, 4'h3, "R7");
    cyc(0, '0, 1, 4'h0, "R6");
    cyc(1, 16'h8001, 0, 4'hA, "R2");
    cyc(0, '0, 0, 4'h5, "R8");
    cyc(0, '0, 1, 4'h5, "R4");
    cyc(0, '0, 1, 4'h5, "R4");
    cyc(0, '0, 1, 4'h5, "R6");
    cyc(1, 16'hFFFF, 0, 4'hF, "R3");
    for (int k = 0; k < 16; k++) cyc(0, '0, 1, 4'h1, "R4");
    cyc(1, 16'h0110, 0, 4'h2, "R2");
    cyc(1, 16'h0C00, 1, 4'h6, "R5");
    cyc(0, '0, 1, 4'h6, "R4");
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 2)      cyc(1, N'($urandom), r == 1, 4'($urandom), r == 1 ? "R5" : "R2");
      else if (r < 7) cyc(0, N'($urandom), 1, 4'($urandom), "R4");
      else            cyc(0, N'($urandom), 0, 4'($urandom), "R8");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule